// File: doc/BRIEF.md
# Dual Overlay Code Sequencer

This block holds two programmable secondary (overlay) code sequences used to stretch coherent integration beyond one primary code period, and steps through them together. On every primary-code epoch pulse it presents the present chip of each sequence and moves both positions forward, wrapping each one at its own programmed length. A downstream correlator uses the chips to undo the overlay sign flips. The correlation arithmetic itself is not part of this block.

The host programs the block through a simple register write port. Code bits are loaded in packed 20-bit words through one register per sequence. The same register also carries a store strobe and a word-pointer step bit, so a single write can both store a word and move to the next slot. The host also writes a shared length register, an enable bit and a self-clearing pointer-reset bit. When the `pilot_mode_i` pin is high, sequence 0 carries the pilot overlay and sequence 1 the data overlay. When it is low, only sequence 0 is stepped and it carries the data overlay.

Top module: `overlay_code_sequencer`

## Requirements
- R1: A write to address 26 (sequence 0) or 27 (sequence 1) with bit 23 set stores bits [19:0] into that sequence's word at its current write slot. A write with bit 23 clear stores nothing.
- R2: A sequence write with bit 20 set moves that sequence's write slot to the next word after any store in the same write. With bit 20 clear the slot stays, so a later strobed write overwrites the same word.
- R3: A write to address 18 with bit 2 set returns both write slots and both read positions to the start of their memories.
- R4: Bit 1 of address 18 is the enable, and it is held in a register. While it is 0, every epoch yields chip value 0 on both sequences and no read position moves.
- R5: An epoch pulse at a clock edge makes `chip_valid_o` high for exactly the following cycle. During that cycle `chip_o[s]` holds the chip at sequence s's read position, with 1 meaning inversion and 0 meaning no inversion. Chips are taken from word 0 upward and from the least significant bit first within each word.
- R6: After each epoch a read position advances by one. A position that has reached its programmed length minus 1 wraps to 0.
- R7: While `pilot_mode_i` is low, sequence 1 is not stepped and `chip_o[1]` is 0 on every epoch.
- R8: A write to address 25 sets sequence 0's length from bits [7:0] and sequence 1's length from bits [23:16]. The two sequences wrap independently.
- R9: After reset the enable and both lengths are 0, all positions are at 0, and `chip_valid_o` and `chip_o` are 0.
- R10: A write to any other address changes neither the code memories, the lengths, the enable nor the positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pilot_mode_i | input | 1 | 1: both sequences stepped (pilot + data); 0: sequence 0 only |
| reg_wr_i | input | 1 | Register write enable, one cycle per write |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| epoch_i | input | 1 | Primary-code epoch pulse |
| chip_valid_o | output | 1 | High for one cycle after each epoch |
| chip_o | output | 2 | Overlay chip per sequence, 1 = invert |

## Verification
The assertions assume that `epoch_i` is a clean single-cycle pulse and that a pointer reset never lands on the same edge as an epoch. They also assume that lengths only change while no wrap is pending. The stimulus keeps to this: every register write and every epoch is separated by at least one idle cycle, and lengths are rewritten only between epochs. Sequence 1's length is set to zero before pilot mode is dropped, as the block expects when pilot tracking is off.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int WORD_BITS     = 20;
    localparam int STROBE_BIT    = 23;
    localparam int STEP_BIT      = 20;
    localparam int LEN1_OFS      = 16;
    localparam int CTRL_EN_BIT   = 1;
    localparam int CTRL_CLR_BIT  = 2;
    localparam logic [4:0] ADDR_CTRL = 5'd18;
    localparam logic [4:0] ADDR_LENS = 5'd25;
    localparam logic [4:0] ADDR_SEQ0 = 5'd26;
    localparam logic [4:0] ADDR_SEQ1 = 5'd27;
    localparam int NUM_SEQ       = 2;
endpackage

// File: rtl/ovl_code_store.sv
module ovl_code_store #(
    parameter int WORDS     = 10,
    parameter int WORD_BITS = 20,
    localparam int AW       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 wr_i,
    input  logic                 strobe_i,
    input  logic                 step_i,
    input  logic [WORD_BITS-1:0] data_i,
    input  logic [AW-1:0]        rd_word_i,
    output logic [WORD_BITS-1:0] rd_data_o
);
    typedef struct packed {
        logic [WORDS-1:0][WORD_BITS-1:0] mem;
        logic [AW-1:0]                   wptr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.wptr = '0;
        end else if (wr_i) begin
            if (strobe_i) begin
                st_d.mem[st_q.wptr] = data_i;
            end
            if (step_i) begin
                st_d.wptr = (st_q.wptr == AW'(WORDS - 1)) ? '0 : st_q.wptr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_word_i < AW'(WORDS)) rd_data_o = st_q.mem[rd_word_i];
    end

    // R3: pointer reset clears the write slot
    a_r3_wptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.wptr == '0));
    // R2: a step bit moves the write slot by one word
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && step_i && !clr_i && st_q.wptr != AW'(WORDS - 1))
        |=> (st_q.wptr == $past(st_q.wptr) + AW'(1)));
    // R1: without a strobed write the memory keeps its contents
    a_r1_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && strobe_i && !clr_i) |=> $stable(st_q.mem));
endmodule

// File: rtl/ovl_chip_stepper.sv
module ovl_chip_stepper #(
    parameter int LEN_W     = 8,
    parameter int WORD_BITS = 20,
    parameter int AW        = 4,
    localparam int BW       = $clog2(WORD_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 adv_i,
    input  logic [LEN_W-1:0]     len_i,
    input  logic [WORD_BITS-1:0] rd_data_i,
    output logic [AW-1:0]        rd_word_o,
    output logic                 chip_o
);
    typedef struct packed {
        logic [LEN_W-1:0] pos;
        logic [AW-1:0]    word;
        logic [BW-1:0]    bitx;
    } step_t;

    step_t sp_d, sp_q;
    logic  at_last;

    assign at_last = (len_i == '0) || (sp_q.pos == len_i - LEN_W'(1));

    always_comb begin
        sp_d = sp_q;
        if (clr_i) begin
            sp_d = '0;
        end else if (adv_i) begin
            if (at_last) begin
                sp_d = '0;
            end else begin
                sp_d.pos = sp_q.pos + LEN_W'(1);
                if (sp_q.bitx == BW'(WORD_BITS - 1)) begin
                    sp_d.bitx = '0;
                    sp_d.word = sp_q.word + AW'(1);
                end else begin
                    sp_d.bitx = sp_q.bitx + BW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    assign rd_word_o = sp_q.word;
    assign chip_o    = rd_data_i[sp_q.bitx];

    // R6: the last position wraps to the start
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i && len_i != '0 && sp_q.pos == len_i - LEN_W'(1))
        |=> (sp_q.pos == '0));
    // R4: without an advance or a clear the position holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clr_i) |=> $stable(sp_q.pos));
    // R3: a clear returns the read position to the start
    a_r3_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sp_q.pos == '0 && sp_q.word == '0));
endmodule

// File: rtl/overlay_code_sequencer.sv
module overlay_code_sequencer
    import ovl_pkg::*;
#(
    parameter int MAX_LEN = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pilot_mode_i,
    input  logic        reg_wr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    input  logic        epoch_i,
    output logic        chip_valid_o,
    output logic [1:0]  chip_o
);
    localparam int WORDS = (MAX_LEN + WORD_BITS - 1) / WORD_BITS;
    localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic             en;
        logic [LEN_W-1:0] len0;
        logic [LEN_W-1:0] len1;
        logic             vld;
        logic [1:0]       chip;
    } regs_t;

    regs_t rg_d, rg_q;

    logic                 clr;
    logic [NUM_SEQ-1:0]   seq_wr;
    logic [NUM_SEQ-1:0]   adv;
    logic [NUM_SEQ-1:0]   cur_chip;
    logic [LEN_W-1:0]     len_sel  [NUM_SEQ];
    logic [AW-1:0]        rd_word  [NUM_SEQ];
    logic [WORD_BITS-1:0] rd_data  [NUM_SEQ];
    logic                 unused_wdata;

    assign unused_wdata = ^reg_wdata_i;

    assign clr       = reg_wr_i && (reg_addr_i == ADDR_CTRL) && reg_wdata_i[CTRL_CLR_BIT];
    assign seq_wr[0] = reg_wr_i && (reg_addr_i == ADDR_SEQ0);
    assign seq_wr[1] = reg_wr_i && (reg_addr_i == ADDR_SEQ1);
    assign adv[0]    = epoch_i && rg_q.en;
    assign adv[1]    = epoch_i && rg_q.en && pilot_mode_i;
    assign len_sel[0] = rg_q.len0;
    assign len_sel[1] = rg_q.len1;

    always_comb begin
        rg_d     = rg_q;
        rg_d.vld = epoch_i;
        if (reg_wr_i && reg_addr_i == ADDR_CTRL) begin
            rg_d.en = reg_wdata_i[CTRL_EN_BIT];
        end
        if (reg_wr_i && reg_addr_i == ADDR_LENS) begin
            rg_d.len0 = reg_wdata_i[LEN_W-1:0];
            rg_d.len1 = reg_wdata_i[LEN1_OFS +: LEN_W];
        end
        if (epoch_i) begin
            rg_d.chip[0] = adv[0] && cur_chip[0];
            rg_d.chip[1] = adv[1] && cur_chip[1];
        end else begin
            rg_d.chip = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
        ovl_code_store #(
            .WORDS     (WORDS),
            .WORD_BITS (WORD_BITS)
        ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (clr),
            .wr_i      (seq_wr[s]),
            .strobe_i  (reg_wdata_i[STROBE_BIT]),
            .step_i    (reg_wdata_i[STEP_BIT]),
            .data_i    (reg_wdata_i[WORD_BITS-1:0]),
            .rd_word_i (rd_word[s]),
            .rd_data_o (rd_data[s])
        );

        ovl_chip_stepper #(
            .LEN_W     (LEN_W),
            .WORD_BITS (WORD_BITS),
            .AW        (AW)
        ) u_step (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (clr),
            .adv_i     (adv[s]),
            .len_i     (len_sel[s]),
            .rd_data_i (rd_data[s]),
            .rd_word_o (rd_word[s]),
            .chip_o    (cur_chip[s])
        );
    end

    assign chip_valid_o = rg_q.vld;
    assign chip_o       = rg_q.chip;

    // R5: an epoch yields a valid chip on the next cycle
    a_r5_valid: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_i |=> chip_valid_o);
    // R5: no epoch, no valid
    a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !epoch_i |=> (!chip_valid_o && chip_o == 2'b00));
    // R4: disabled sequences give no inversion
    a_r4_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
        (epoch_i && !rg_q.en) |=> (chip_o == 2'b00));
    // R7: sequence 1 idle outside pilot mode
    a_r7_seq1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (epoch_i && !pilot_mode_i) |=> !chip_o[1]);
endmodule

// File: tb/tb_overlay_code_sequencer.sv
module tb_overlay_code_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pilot_mode_i = 1'b1;
    logic        reg_wr_i = 1'b0;
    logic [4:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic        epoch_i = 1'b0;
    logic        chip_valid_o;
    logic [1:0]  chip_o;

    always #4 clk = ~clk;

    overlay_code_sequencer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pilot_mode_i (pilot_mode_i),
        .reg_wr_i     (reg_wr_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .epoch_i      (epoch_i),
        .chip_valid_o (chip_valid_o),
        .chip_o       (chip_o)
    );

    int          checks = 0;
    int          fails  = 0;
    logic [1:0]  exp_q[$];
    string       tag_q[$];
    logic [255:0] code0, code1;
    int          len0 = 0, len1 = 0, p0 = 0, p1 = 0;
    bit          en_m = 1'b0, pilot_m = 1'b1;
    bit          done = 1'b0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    // driver: computes the expected chip pair, then pulses the epoch
    task automatic epoch(string tag);
        logic e0, e1;
        e0 = en_m ? code0[p0] : 1'b0;
        e1 = (en_m && pilot_m) ? code1[p1] : 1'b0;
        if (en_m) begin
            p0 = (len0 == 0 || p0 == len0 - 1) ? 0 : p0 + 1;
            if (pilot_m) p1 = (len1 == 0 || p1 == len1 - 1) ? 0 : p1 + 1;
        end
        exp_q.push_back({e1, e0});
        tag_q.push_back(tag);
        @(negedge clk);
        epoch_i = 1'b1;
        @(negedge clk);
        epoch_i = 1'b0;
    endtask

    task automatic load_seq(int s, int nwords);
        for (int w = 0; w < nwords; w++) begin
            logic [19:0] word;
            word = (s == 0) ? code0[w*20 +: 20] : code1[w*20 +: 20];
            wr((s == 0) ? 5'd26 : 5'd27, (32'h1 << 23) | (32'h1 << 20) | {12'h0, word});
        end
    endtask

    // monitor: pops the scoreboard on every valid chip
    always @(negedge clk) begin
        if (rst_n && chip_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected valid", 1, 0);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(chip_o == e, t, int'(chip_o), int'(e));
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) code0[i] = ((i * 13 + 5) % 7) < 3;
        code1 = '0;
        code1[6:0] = 7'b1001101;

        repeat (3) @(negedge clk);
        chk(chip_valid_o == 1'b0, "R9 valid after reset", int'(chip_valid_o), 0);
        chk(chip_o == 2'b00, "R9 chip after reset", int'(chip_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9/R4: enable is 0 after reset
        epoch("R9 disabled at reset");
        epoch("R9 disabled at reset");

        // R1 R2 R5 R6 R8: load both, run past several wraps
        load_seq(0, 10);
        load_seq(1, 1);
        wr(5'd25, 32'd45 | (32'd7 << 16));
        len0 = 45; len1 = 7;
        wr(5'd18, 32'h2);
        en_m = 1'b1;
        for (int k = 0; k < 60; k++) epoch("R6 wrap / R8 lengths / R5 order");

        // R3 R1 R2: reset pointers, overwrite word 0, write word 1
        wr(5'd18, 32'h6);
        p0 = 0; p1 = 0;
        wr(5'd26, 32'h000F_FFFF);
        wr(5'd26, 32'h0080_0000);
        code0[19:0] = 20'h0;
        wr(5'd26, 32'h0090_0000 | 32'hA5A5A);
        code0[19:0] = 20'hA5A5A;
        wr(5'd26, 32'h0080_0000 | 32'h12345);
        code0[39:20] = 20'h12345;
        for (int k = 0; k < 47; k++) epoch("R1 strobe / R2 step");

        // R3: mid-run read position reset
        wr(5'd18, 32'h6);
        p0 = 0; p1 = 0;
        for (int k = 0; k < 6; k++) epoch("R3 pointer reset");

        // R10: writes elsewhere ignored
        wr(5'd5, 32'h0);
        wr(5'd24, 32'hFFFF_FFFF);
        wr(5'd17, 32'h0);
        for (int k = 0; k < 6; k++) epoch("R10 other address");

        // R4: disable holds positions and gives no inversion
        wr(5'd18, 32'h0);
        en_m = 1'b0;
        for (int k = 0; k < 4; k++) epoch("R4 disabled");
        wr(5'd18, 32'h2);
        en_m = 1'b1;
        for (int k = 0; k < 10; k++) epoch("R4 resume");

        // R7: pilot mode off, sequence 1 length zero
        wr(5'd25, 32'd45);
        len1 = 0;
        @(negedge clk);
        pilot_mode_i = 1'b0;
        pilot_m = 1'b0;
        for (int k = 0; k < 20; k++) epoch("R7 single sequence");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all epochs answered", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule